// File: doc/BRIEF.md
# Two-Wire Shift and Clock-Stretch Unit

This block is the bit-level engine of a slave on a two-wire serial bus. It contains an 8-bit shift register and a 4-bit bit counter. One selectable shift clock advances both of them. That clock can be the bus clock line, an external single-cycle strobe, or a strobe from the host. The block also watches for a START condition and raises a flag when it sees one. It can stretch the bus clock by pulling SCL low, so control logic that runs slowly never misses bus timing. Both bus lines are open-drain. Each line has a level input and a separate pull-low output.

The block does no protocol decoding. It has no address match, no buffering and no message sequencing. The host logic loads and reads the shift register, presets the counter, clears flags and releases the clock hold. For example, a preset of 0 gives a full byte (16 SCL edges), and a preset of 14 gives a single acknowledge bit. Both lines pass through a synchronizer before edge detection. There is no glitch filter and no slew control.

The clock-hold controller is a four-state machine:

- FREE drives nothing.
- START_PEND is entered from any state on a START. It waits for SCL to fall.
- HOLD_START is entered from START_PEND on that SCL fall.
- HOLD_OVF is entered from FREE on a counter overflow in SCL mode.

Writing 1 to the clear of the start flag returns START_PEND or HOLD_START to FREE. Writing 1 to the clear of the overflow flag returns HOLD_OVF to FREE.

Top module: `twi_shift_unit`

## Requirements
- R1: After reset the shift register reads 0xFF, the counter reads 0, both flags are 0 and neither line is pulled low.
- R2: A falling SDA while SCL is high sets the start flag. A falling SDA while SCL is low leaves the flag at 0.
- R3: After a START, SCL is pulled low from the next SCL falling edge on. It stays low, even if the master releases SCL, until the start flag is cleared. SCL is released in the same cycle as the clear.
- R4: In SCL mode (clock source 0), SDA is sampled on each SCL rising edge and shifted in at the LSB on the next falling edge, MSB first. The counter advances on both edges. From a preset of 0, the 8th falling edge wraps the counter to 0 and sets the overflow flag, and the register then holds the received byte.
- R5: An overflow in SCL mode pulls SCL low until the overflow flag is cleared. An overflow under either strobe source sets the flag but does not pull SCL low.
- R6: A counter preset of 14 makes one SCL bit (one rise and one fall) overflow the counter.
- R7: SDA is pulled low exactly when the SDA output enable is 1 and the shift register MSB is 0. During a transmit, each falling SCL edge presents the next bit.
- R8: With clock source 1, each cycle of the external strobe shifts in the SDA level and adds one to the counter. SCL edges and the host strobe then have no effect.
- R9: With clock source 2, each cycle of the host strobe shifts in the SDA level and adds one to the counter. Sixteen strobes from a preset of 0 set the overflow flag.
- R10: A host load of the shift register, or a preset of the counter, takes priority over a shift or count in the same cycle. Writing 1 to a flag clear drops that flag, unless the flag is being set in the same cycle.
- R11: The start interrupt output is 1 exactly when the start flag is 1 and the start interrupt enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sda_i | input | 1 | SDA line level |
| scl_i | input | 1 | SCL line level |
| sda_drive_low_o | output | 1 | Pull SDA low |
| scl_drive_low_o | output | 1 | Pull SCL low (clock stretch) |
| clk_src_i | input | 2 | Shift clock source: 0 SCL, 1 external strobe, 2 host strobe |
| ext_strobe_i | input | 1 | External periodic strobe, one-cycle pulses |
| sw_strobe_i | input | 1 | Host strobe, one-cycle pulses |
| sda_out_en_i | input | 1 | Let the shift register MSB drive SDA |
| data_wr_en_i | input | 1 | Load the shift register |
| data_wr_i | input | 8 | Value to load |
| data_o | output | 8 | Shift register contents |
| cnt_wr_en_i | input | 1 | Preset the bit counter |
| cnt_wr_i | input | 4 | Counter preset value |
| cnt_o | output | 4 | Bit counter value |
| clr_start_i | input | 1 | Write-1 clear of the start flag |
| clr_ovf_i | input | 1 | Write-1 clear of the overflow flag |
| start_irq_en_i | input | 1 | Start interrupt enable |
| start_flag_o | output | 1 | START seen |
| ovf_flag_o | output | 1 | Counter overflowed |
| start_irq_o | output | 1 | Start interrupt |

## Verification
The bench builds the unit with its default parameters: an 8-bit register, a 4-bit counter and a two-flop synchronizer. With these values a full byte takes 16 counted SCL edges, and a preset of 14 gives a single acknowledge bit. Both fit in short directed bus sequences. The synchronizer depth sets a fixed lag of three system cycles from a line change to any flag or hold change. This lets the bench settle each bus step within a few cycles and check the hold entry and release at the ports through a modelled open-drain bus.

// File: rtl/twi_shift_pkg.sv
package twi_shift_pkg;
    typedef enum logic [1:0] {
        SRC_SCL = 2'd0,
        SRC_EXT = 2'd1,
        SRC_SW  = 2'd2
    } shift_src_e;

    typedef enum logic [1:0] {
        HS_FREE,
        HS_START_PEND,
        HS_HOLD_START,
        HS_HOLD_OVF
    } hold_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic prev_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic          prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= line_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[LAST-1:0], line_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[LAST];
    end

    assign lvl_o  = chain_q[LAST];
    assign prev_o = prev_q;
endmodule

// File: rtl/twi_shift_core.sv
module twi_shift_core
    import twi_shift_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  shift_src_e        src_i,
    input  logic              sda_lvl_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              ext_stb_i,
    input  logic              sw_stb_i,
    input  logic              data_wr_en_i,
    input  logic [DATA_W-1:0] data_wr_i,
    input  logic              cnt_wr_en_i,
    input  logic [CNT_W-1:0]  cnt_wr_i,
    output logic [DATA_W-1:0] sreg_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              ovf_evt_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [DATA_W-1:0] sreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              sample_q;
    logic              do_sample, do_shift, do_count, shift_bit;

    always_comb begin
        do_sample = 1'b0;
        do_shift  = 1'b0;
        shift_bit = sda_lvl_i;
        unique case (src_i)
            SRC_SCL: begin
                do_sample = scl_rise_i;
                do_shift  = scl_fall_i;
                shift_bit = sample_q;
            end
            SRC_EXT: do_shift = ext_stb_i;
            SRC_SW:  do_shift = sw_stb_i;
            default: ;
        endcase
        do_count  = do_sample | do_shift;
        ovf_evt_o = do_count && (cnt_q == CNT_TOP) && !cnt_wr_en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q   <= '1;
            cnt_q    <= '0;
            sample_q <= 1'b1;
        end else begin
            if (do_sample)         sample_q <= sda_lvl_i;
            if (data_wr_en_i)      sreg_q   <= data_wr_i;
            else if (do_shift)     sreg_q   <= {sreg_q[DATA_W-2:0], shift_bit};
            if (cnt_wr_en_i)       cnt_q    <= cnt_wr_i;
            else if (do_count)     cnt_q    <= cnt_q + 1'b1;
        end
    end

    assign sreg_o = sreg_q;
    assign cnt_o  = cnt_q;

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt_o |=> (cnt_q == '0)); // R4
    AST_SHIFT_LSB_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (do_shift && !data_wr_en_i) |=> (sreg_q[0] == $past(shift_bit))); // R4
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr_en_i |=> (sreg_q == $past(data_wr_i))); // R10
endmodule

// File: rtl/twi_hold_ctrl.sv
module twi_hold_ctrl
    import twi_shift_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  shift_src_e src_i,
    input  logic       sda_fall_i,
    input  logic       scl_lvl_i,
    input  logic       scl_fall_i,
    input  logic       ovf_evt_i,
    input  logic       clr_start_i,
    input  logic       clr_ovf_i,
    output logic       start_flag_o,
    output logic       ovf_flag_o,
    output logic       scl_hold_o
);
    hold_state_e state_q, state_d;
    logic        start_flag_q, ovf_flag_q;
    logic        start_evt;

    assign start_evt = sda_fall_i && scl_lvl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_flag_q <= 1'b0;
            ovf_flag_q   <= 1'b0;
        end else begin
            if (start_evt)        start_flag_q <= 1'b1;
            else if (clr_start_i) start_flag_q <= 1'b0;
            if (ovf_evt_i)        ovf_flag_q   <= 1'b1;
            else if (clr_ovf_i)   ovf_flag_q   <= 1'b0;
        end
    end

    always_comb begin
        state_d = state_q;
        if (start_evt) begin
            state_d = HS_START_PEND;
        end else begin
            unique case (state_q)
                HS_FREE:
                    if (ovf_evt_i && src_i == SRC_SCL) state_d = HS_HOLD_OVF;
                HS_START_PEND:
                    if (clr_start_i)     state_d = HS_FREE;
                    else if (scl_fall_i) state_d = HS_HOLD_START;
                HS_HOLD_START:
                    if (clr_start_i)     state_d = HS_FREE;
                HS_HOLD_OVF:
                    if (clr_ovf_i)       state_d = HS_FREE;
                default:                 state_d = HS_FREE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            HS_HOLD_START, HS_HOLD_OVF: scl_hold_o = 1'b1;
            default:                    scl_hold_o = 1'b0;
        endcase
    end

    assign start_flag_o = start_flag_q;
    assign ovf_flag_o   = ovf_flag_q;

    AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> start_flag_q); // R2
    AST_HOLD_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold_o |-> (start_flag_q || ovf_flag_q)); // R3
    AST_OVF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_HOLD_OVF && clr_ovf_i && !start_evt) |=> !scl_hold_o); // R5
    AST_CLR_START: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_start_i && !start_evt) |=> !start_flag_q); // R10
endmodule

// File: rtl/twi_shift_unit.sv
module twi_shift_unit
    import twi_shift_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_i,
    input  logic              scl_i,
    output logic              sda_drive_low_o,
    output logic              scl_drive_low_o,
    input  logic [1:0]        clk_src_i,
    input  logic              ext_strobe_i,
    input  logic              sw_strobe_i,
    input  logic              sda_out_en_i,
    input  logic              data_wr_en_i,
    input  logic [DATA_W-1:0] data_wr_i,
    output logic [DATA_W-1:0] data_o,
    input  logic              cnt_wr_en_i,
    input  logic [CNT_W-1:0]  cnt_wr_i,
    output logic [CNT_W-1:0]  cnt_o,
    input  logic              clr_start_i,
    input  logic              clr_ovf_i,
    input  logic              start_irq_en_i,
    output logic              start_flag_o,
    output logic              ovf_flag_o,
    output logic              start_irq_o
);
    shift_src_e src;
    logic sda_lvl, sda_prev, scl_lvl, scl_prev;
    logic sda_fall, scl_rise, scl_fall, ovf_evt;

    assign src = shift_src_e'(clk_src_i);

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .lvl_o(sda_lvl), .prev_o(sda_prev));
    twi_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .lvl_o(scl_lvl), .prev_o(scl_prev));

    assign sda_fall = !sda_lvl && sda_prev;
    assign scl_rise = scl_lvl && !scl_prev;
    assign scl_fall = !scl_lvl && scl_prev;

    twi_shift_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .src_i(src), .sda_lvl_i(sda_lvl),
        .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
        .ext_stb_i(ext_strobe_i), .sw_stb_i(sw_strobe_i),
        .data_wr_en_i(data_wr_en_i), .data_wr_i(data_wr_i),
        .cnt_wr_en_i(cnt_wr_en_i), .cnt_wr_i(cnt_wr_i),
        .sreg_o(data_o), .cnt_o(cnt_o), .ovf_evt_o(ovf_evt));

    twi_hold_ctrl u_hold (
        .clk(clk), .rst_n(rst_n), .src_i(src), .sda_fall_i(sda_fall),
        .scl_lvl_i(scl_lvl), .scl_fall_i(scl_fall), .ovf_evt_i(ovf_evt),
        .clr_start_i(clr_start_i), .clr_ovf_i(clr_ovf_i),
        .start_flag_o(start_flag_o), .ovf_flag_o(ovf_flag_o),
        .scl_hold_o(scl_drive_low_o));

    assign sda_drive_low_o = sda_out_en_i && !data_o[DATA_W-1];
    assign start_irq_o     = start_flag_o && start_irq_en_i;
endmodule

// File: tb/twi_shift_unit_tb.sv
module twi_shift_unit_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic sda_m = 1'b1, scl_m = 1'b1;
    logic sda_bus, scl_bus;
    logic sda_dl, scl_dl;
    logic [1:0] clk_src = 2'd0;
    logic ext_stb = 1'b0, sw_stb = 1'b0, sda_oe = 1'b0;
    logic data_we = 1'b0, cnt_we = 1'b0, clr_st = 1'b0, clr_ov = 1'b0, irq_en = 1'b0;
    logic [7:0] data_w = 8'h00, data_r;
    logic [3:0] cnt_w = 4'd0, cnt_r;
    logic st_flag, ov_flag, st_irq;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    assign sda_bus = sda_m & ~sda_dl;
    assign scl_bus = scl_m & ~scl_dl;

    twi_shift_unit u_dut (
        .clk(clk), .rst_n(rst_n), .sda_i(sda_bus), .scl_i(scl_bus),
        .sda_drive_low_o(sda_dl), .scl_drive_low_o(scl_dl),
        .clk_src_i(clk_src), .ext_strobe_i(ext_stb), .sw_strobe_i(sw_stb),
        .sda_out_en_i(sda_oe), .data_wr_en_i(data_we), .data_wr_i(data_w),
        .data_o(data_r), .cnt_wr_en_i(cnt_we), .cnt_wr_i(cnt_w), .cnt_o(cnt_r),
        .clr_start_i(clr_st), .clr_ovf_i(clr_ov), .start_irq_en_i(irq_en),
        .start_flag_o(st_flag), .ovf_flag_o(ov_flag), .start_irq_o(st_irq));

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mbit(input logic b);
        sda_m = b; cyc(4);
        scl_m = 1'b1; cyc(6);
        scl_m = 1'b0; cyc(6);
    endtask

    task automatic host_load(input logic [7:0] v);
        @(negedge clk); data_w = v; data_we = 1'b1;
        @(negedge clk); data_we = 1'b0;
    endtask

    task automatic host_preset(input logic [3:0] v);
        @(negedge clk); cnt_w = v; cnt_we = 1'b1;
        @(negedge clk); cnt_we = 1'b0;
    endtask

    task automatic host_clr(input logic s, input logic o);
        @(negedge clk); clr_st = s; clr_ov = o;
        @(negedge clk); clr_st = 1'b0; clr_ov = 1'b0;
    endtask

    task automatic pulse_ext();
        @(negedge clk); ext_stb = 1'b1;
        @(negedge clk); ext_stb = 1'b0;
    endtask

    task automatic pulse_sw();
        @(negedge clk); sw_stb = 1'b1;
        @(negedge clk); sw_stb = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 data", data_r, 8'hFF);
        chk("R1 cnt", cnt_r, 0);
        chk("R1 flags", {st_flag, ov_flag}, 0);
        chk("R1 drives", {sda_dl, scl_dl}, 0);
    endtask

    task automatic t_start_hold();
        scl_m = 1'b0; cyc(6);
        sda_m = 1'b0; cyc(6);
        chk("R2 no start with SCL low", st_flag, 0);
        sda_m = 1'b1; cyc(4);
        scl_m = 1'b1; cyc(6);
        sda_m = 1'b0; cyc(6);
        chk("R2 start flag", st_flag, 1);
        chk("R11 irq disabled", st_irq, 0);
        irq_en = 1'b1; cyc(1);
        chk("R11 irq enabled", st_irq, 1);
        chk("R3 no hold before SCL fall", scl_dl, 0);
        scl_m = 1'b0; cyc(6);
        chk("R3 hold after SCL fall", scl_dl, 1);
        scl_m = 1'b1; cyc(6);
        chk("R3 hold while master releases", scl_bus, 0);
        scl_m = 1'b0; cyc(2);
        host_preset(4'd0);
        chk("R10 preset", cnt_r, 0);
        @(negedge clk); clr_st = 1'b1;
        @(posedge clk); #1;
        chk("R3 release with clear", scl_dl, 0);
        @(negedge clk); clr_st = 1'b0;
        chk("R10 start flag cleared", st_flag, 0);
        chk("R11 irq drops", st_irq, 0);
        irq_en = 1'b0;
    endtask

    task automatic t_receive();
        logic [7:0] v = 8'hA5;
        for (int i = 7; i >= 1; i--) mbit(v[i]);
        chk("R4 count after 7 bits", cnt_r, 14);
        chk("R4 no overflow yet", ov_flag, 0);
        mbit(v[0]);
        chk("R4 byte received", data_r, 8'hA5);
        chk("R4 counter wrapped", cnt_r, 0);
        chk("R4 overflow flag", ov_flag, 1);
        chk("R5 overflow hold", scl_dl, 1);
    endtask

    task automatic t_ack();
        host_load(8'h00);
        sda_oe = 1'b1; cyc(1);
        chk("R7 ACK drive", sda_dl, 1);
        host_preset(4'd14);
        host_clr(1'b0, 1'b1);
        chk("R5 released on clear", scl_dl, 0);
        chk("R10 ovf cleared", ov_flag, 0);
        mbit(1'b1);
        chk("R6 one-bit overflow", ov_flag, 1);
        chk("R6 counter wrapped", cnt_r, 0);
        chk("R6 hold", scl_dl, 1);
        sda_oe = 1'b0;
    endtask

    task automatic t_transmit();
        logic [7:0] v = 8'h6C;
        host_load(v);
        host_preset(4'd0);
        sda_oe = 1'b1;
        host_clr(1'b0, 1'b1);
        for (int i = 7; i >= 0; i--) begin
            cyc(2);
            chk("R7 tx bit", sda_dl, {31'd0, ~v[i]});
            mbit(1'b1);
        end
        chk("R7 echo of sent byte", data_r, 8'h6C);
        chk("R5 ovf after tx", ov_flag, 1);
        sda_oe = 1'b0;
        host_clr(1'b0, 1'b1);
    endtask

    task automatic t_ext();
        clk_src = 2'd1;
        host_preset(4'd3);
        sda_m = 1'b1; cyc(6); pulse_ext();
        sda_m = 1'b0; cyc(6); pulse_ext();
        sda_m = 1'b1; cyc(6); pulse_ext();
        chk("R8 count", cnt_r, 6);
        chk("R8 data", data_r, 8'h65);
        scl_m = 1'b1; cyc(6); scl_m = 1'b0; cyc(6);
        scl_m = 1'b1; cyc(6); scl_m = 1'b0; cyc(6);
        pulse_sw(); cyc(2);
        chk("R8 SCL and host strobe ignored cnt", cnt_r, 6);
        chk("R8 SCL and host strobe ignored data", data_r, 8'h65);
    endtask

    task automatic t_sw();
        clk_src = 2'd2;
        host_preset(4'd0);
        sda_m = 1'b0; cyc(6);
        for (int i = 0; i < 15; i++) pulse_sw();
        pulse_ext(); cyc(2);
        chk("R9 count 15, ext ignored", cnt_r, 15);
        chk("R9 no overflow yet", ov_flag, 0);
        pulse_sw(); cyc(2);
        chk("R9 overflow", ov_flag, 1);
        chk("R9 wrap", cnt_r, 0);
        chk("R9 data shifted", data_r, 8'h00);
        chk("R5 no hold in strobe mode", scl_dl, 0);
    endtask

    task automatic t_override();
        @(negedge clk); data_w = 8'h3C; data_we = 1'b1; cnt_w = 4'd9; cnt_we = 1'b1; sw_stb = 1'b1;
        @(negedge clk); data_we = 1'b0; cnt_we = 1'b0; sw_stb = 1'b0;
        chk("R10 load beats shift", data_r, 8'h3C);
        chk("R10 preset beats count", cnt_r, 9);
        host_clr(1'b0, 1'b1);
        chk("R10 ovf clear", ov_flag, 0);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_start_hold();
        t_receive();
        t_ack();
        t_transmit();
        t_ext();
        t_sw();
        t_override();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule